// File: doc/BRIEF.md
# 8b/10b Line Encoder with Comma Resynchronization

This block turns byte characters into 10-bit 8b/10b code groups for a transmit lane. Each byte comes with a control flag. The block keeps the running disparity and makes each code group a standard one. A single mode select picks how many bytes are encoded per clock. The narrow setting encodes one byte per clock on lane 0. The wide setting encodes two bytes per clock on lanes 0 and 1. In the wide setting lane 0 is the earlier character, and the disparity it leaves is the disparity that lane 1 starts from.

The digital reset doubles as a link resynchronization control. While reset is held, every lane shows the comma K28.5 taken from the negative-disparity column, and the inputs have no effect. After release, disparity starts negative. The block sends exactly three K28.5 commas, and then user characters follow with no gap. Each code group appears on the output one clock after its character is accepted.

The input is a valid/ready stream. `in_ready` is low during reset and during the comma preamble, and stays high after that until the next reset. A character transfers on a clock edge where `in_valid` and `in_ready` are both high. The source must hold its data while `in_ready` is low. On a cycle with `in_ready` high and `in_valid` low, the block sends an idle comma. The output side has no back-pressure: the block produces a code group word on every clock.

Top module: `enc8b10b_sync`

## Requirements
- R1: While `rst` is high, every lane of `code_o` is 10'h17C (K28.5, negative column). In this state `rd_o` is 0, `in_ready` is 0 and `bad_o` is 0, whatever `in_data`, `in_k` and `in_valid` carry.
- R2: Narrow mode (`wide_i`=0) after reset release:
  - The first three clocks put K28.5 on lane 0 as 10'h17C, 10'h283, 10'h17C.
  - `in_ready` is 0 for the first two of those clocks and 1 from the third onward.
  - The character presented in the third clock is the next code group on the output.
- R3: Wide mode (`wide_i`=1) after reset release:
  - The first word is {lane1 10'h17C, lane0 10'h17C}. Lane 0 of this word is a filler slot that leaves disparity unchanged.
  - The second word is {10'h17C, 10'h283}.
  - This makes exactly three synchronizing commas. `in_ready` is 1 from the second word onward.
- R4: Each code group is packed as abcdei fghj, with bit a at bit 0 (sent first). Examples:
  - D21.5 gives 10'h155.
  - D0.0 at positive disparity gives 10'h346.
  - D7.0 at negative disparity gives 10'h347.
- R5: `rd_o` gives the running disparity (1 = positive) after the most recent code group. The disparity changes only after a code group whose counts of ones and zeros differ. A group with six ones follows only from negative disparity.
- R6: Data D.x.7 uses the alternate sub-block in two cases, to avoid runs of five equal bits:
  - x is 17, 18 or 20 and the disparity after the 6-bit part is negative.
  - x is 11, 13 or 14 and that disparity is positive.
  - Examples: D17.7 (8'hF1) at negative gives 10'h3B1, and at positive gives 10'h231. D11.7 (8'hEB) at positive gives 10'h04B, and at negative gives 10'h1CB.
- R7: A byte is {y[2:0], x[4:0]}. With the flag set, twelve values are valid control characters: x=28 with any y, and y=7 with x of 23, 27, 29 or 30. Examples:
  - K28.5 (8'hBC) gives 10'h283 at positive disparity.
  - K23.7 (8'hF7) gives 10'h3A8 at positive disparity.
  - K28.1 (8'h3C) gives 10'h27C at negative disparity.
- R8: A set flag with any other byte is encoded as a data character, and that lane's `bad_o` bit is 1 in the same clock as its code group. For example, 8'h38 with the flag at positive disparity gives 10'h24C with `bad_o` set.
- R9: In wide mode, `in_data[7:0]`/`in_k[0]` produce lane 0 (`code_o[9:0]`) and `in_data[15:8]`/`in_k[1]` produce lane 1 (`code_o[19:10]`). Lane 1 starts from the disparity lane 0 leaves, and `rd_o` follows lane 1.
- R10: A character transfers only when `in_valid` and `in_ready` are both high. Its code group is on `code_o` after exactly one clock edge. Inputs offered while `in_ready` is low are not consumed.
- R11: When `in_ready` is 1 and `in_valid` is 0, each active lane carries K28.5 at its own running disparity.
- R12: In narrow mode, after the first clock following reset release, `code_o[19:10]` is zero and `bad_o[1]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high digital reset, also the resynchronization request |
| wide_i | input | 1 | 0: one byte per clock, 1: two bytes per clock; change only under reset |
| in_valid | input | 1 | Input characters are offered |
| in_ready | output | 1 | Block accepts characters this cycle |
| in_data | input | 16 | Byte for lane 0 in [7:0], byte for lane 1 in [15:8] |
| in_k | input | 2 | Control flag per lane |
| code_o | output | 20 | Lane 0 code group in [9:0], lane 1 in [19:10], bit 0 of each sent first |
| rd_o | output | 1 | Running disparity after the last code group, 1 = positive |
| bad_o | output | 2 | Per lane: control flag was set on a byte that is not a valid control character |

## Verification
Two events can land in the same clock. The end of the comma preamble and the first user character meet there: `in_valid` is held high through reset and the whole preamble with junk data. The bench judges that the third comma is followed at once by the first real character, and that none of the junk appears. The second pair is an invalid control request on lane 0 together with a data character on lane 1 in one wide word. That word is judged on lane 1's code group: it must be taken from the disparity left by lane 0's data-encoded group, while `bad_o` marks only lane 0. The alternate D.x.7 choice is also driven in both lanes, where the lane 1 result depends on lane 0's disparity.

// File: rtl/enc8b10b_pkg.sv
package enc8b10b_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int SYM_W = 10;
  localparam int BYTE_W = 8;
  localparam logic [SYM_W-1:0] COMMA_NEG = 10'h17C;
  localparam logic [BYTE_W-1:0] COMMA_BYTE = 8'hBC;

  typedef enum logic [1:0] {SEL_DATA, SEL_COMMA, SEL_FILL} lane_sel_e;

  typedef struct packed {
    logic [SYM_W-1:0] code;
    logic             rd;
    logic             bad;
  } enc_res_t;

  // 6-bit sub-block for negative disparity, bit 5 = a .. bit 0 = i
  function automatic logic [5:0] six_base(input logic [4:0] x);
    case (x)
      5'd0:  return 6'b100111;  5'd1:  return 6'b011101;
      5'd2:  return 6'b101101;  5'd3:  return 6'b110001;
      5'd4:  return 6'b110101;  5'd5:  return 6'b101001;
      5'd6:  return 6'b011001;  5'd7:  return 6'b111000;
      5'd8:  return 6'b111001;  5'd9:  return 6'b100101;
      5'd10: return 6'b010101;  5'd11: return 6'b110100;
      5'd12: return 6'b001101;  5'd13: return 6'b101100;
      5'd14: return 6'b011100;  5'd15: return 6'b010111;
      5'd16: return 6'b011011;  5'd17: return 6'b100011;
      5'd18: return 6'b010011;  5'd19: return 6'b110010;
      5'd20: return 6'b001011;  5'd21: return 6'b101010;
      5'd22: return 6'b011010;  5'd23: return 6'b111010;
      5'd24: return 6'b110011;  5'd25: return 6'b100110;
      5'd26: return 6'b010110;  5'd27: return 6'b110110;
      5'd28: return 6'b001110;  5'd29: return 6'b101110;
      5'd30: return 6'b011110;  default: return 6'b101011;
    endcase
  endfunction

  // 4-bit sub-block for negative disparity, bit 3 = f .. bit 0 = j
  function automatic logic [3:0] four_base(input logic [2:0] y);
    case (y)
      3'd0: return 4'b1011;  3'd1: return 4'b1001;
      3'd2: return 4'b0101;  3'd3: return 4'b1100;
      3'd4: return 4'b1101;  3'd5: return 4'b1010;
      3'd6: return 4'b0110;  default: return 4'b1110;
    endcase
  endfunction

  function automatic enc_res_t encode(input logic [7:0] d, input logic k, input logic rd);
    logic [4:0] x;
    logic [2:0] y;
    logic       kok, use_k, rd6, alt;
    logic [5:0] b6, s;
    logic [3:0] b4, f;
    enc_res_t   r;
    x = d[4:0];
    y = d[7:5];
    kok = (x == 5'd28) ||
          (y == 3'd7 && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30));
    use_k = k && kok;
    r.bad = k && !kok;
    b6 = six_base(x);
    if (use_k && x == 5'd28)          s = rd ? 6'b110000 : 6'b001111;
    else if (x == 5'd7)               s = rd ? 6'b000111 : 6'b111000;
    else if (rd && $countones(b6) != 3) s = ~b6;
    else                              s = b6;
    rd6 = rd ^ ($countones(s) != 3);
    alt = (y == 3'd7) &&
          (use_k ||
           (!rd6 && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
           (rd6 && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
    b4 = four_base(y);
    if (alt)                               f = rd6 ? 4'b1000 : 4'b0111;
    else if (y == 3'd3)                    f = rd6 ? 4'b0011 : 4'b1100;
    else if (rd6 && $countones(b4) != 2)   f = ~b4;
    else                                   f = b4;
    if (use_k && x == 5'd28 && !rd6 &&
        (y == 3'd1 || y == 3'd2 || y == 3'd5 || y == 3'd6))
      f = ~f;
    r.rd = rd6 ^ ($countones(f) != 2);
    for (int i = 0; i < 6; i++) r.code[i] = s[5-i];
    for (int i = 0; i < 4; i++) r.code[6+i] = f[3-i];
    return r;
  endfunction
endpackage

// File: rtl/enc8b10b_lane.sv
module enc8b10b_lane
  import enc8b10b_pkg::*;
(
  input  logic [BYTE_W-1:0] data_i,
  input  logic              k_i,
  input  logic              rd_i,
  input  lane_sel_e         sel_i,
  output logic [SYM_W-1:0]  code_o,
  output logic              rd_o,
  output logic              bad_o
);
  timeunit 1ns;
  timeprecision 100ps;

  enc_res_t res;

  always_comb begin
    case (sel_i)
      SEL_COMMA: res = encode(COMMA_BYTE, 1'b1, rd_i);
      SEL_FILL: begin
        res.code = COMMA_NEG;
        res.rd   = rd_i;
        res.bad  = 1'b0;
      end
      default:   res = encode(data_i, k_i, rd_i);
    endcase
  end

  assign code_o = res.code;
  assign rd_o   = res.rd;
  assign bad_o  = res.bad;
endmodule

// File: rtl/enc8b10b_sync_ctrl.sv
module enc8b10b_sync_ctrl
  import enc8b10b_pkg::*;
#(
  parameter int NLANE    = 2,
  parameter int SYNC_CNT = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wide_i,
  input  logic                  in_valid_i,
  output logic                  ready_o,
  output lane_sel_e [NLANE-1:0] sel_o
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int WIDE_WORDS = (SYNC_CNT + NLANE - 1) / NLANE;
  localparam int PAD        = WIDE_WORDS * NLANE - SYNC_CNT;
  localparam int CW         = $clog2(SYNC_CNT + 1) < 1 ? 1 : $clog2(SYNC_CNT + 1);

  logic [CW-1:0] cnt, need;

  assign need    = wide_i ? CW'(WIDE_WORDS) : CW'(SYNC_CNT);
  assign ready_o = (cnt == need);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)           cnt <= '0;
    else if (!ready_o) cnt <= cnt + CW'(1);
  end

  always_comb begin
    for (int l = 0; l < NLANE; l++) begin
      int slot;
      slot = int'(cnt) * (wide_i ? NLANE : 1) + l;
      if (ready_o)                   sel_o[l] = in_valid_i ? SEL_DATA : SEL_COMMA;
      else if (wide_i && slot < PAD) sel_o[l] = SEL_FILL;
      else                           sel_o[l] = SEL_COMMA;
    end
  end

  // R10: once open, the input stays open until the next reset
  a_r10_ready_holds: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> ready_o);
  // R2: the first clock after release is always part of the preamble
  a_r2_preamble_closed: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !ready_o);
endmodule

// File: rtl/enc8b10b_sync.sv
module enc8b10b_sync
  import enc8b10b_pkg::*;
#(
  parameter int NLANE    = 2,
  parameter int SYNC_CNT = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wide_i,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [NLANE*BYTE_W-1:0] in_data,
  input  logic [NLANE-1:0]        in_k,
  output logic [NLANE*SYM_W-1:0]  code_o,
  output logic                    rd_o,
  output logic [NLANE-1:0]        bad_o
);
  timeunit 1ns;
  timeprecision 100ps;

  lane_sel_e [NLANE-1:0]         sel;
  logic [NLANE:0]                rd_chain;
  logic [NLANE-1:0][SYM_W-1:0]   lane_code, code_q;
  logic [NLANE-1:0]              lane_bad, bad_q;
  logic                          rd_q, rd_next;

  enc8b10b_sync_ctrl #(.NLANE(NLANE), .SYNC_CNT(SYNC_CNT)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wide_i     (wide_i),
    .in_valid_i (in_valid),
    .ready_o    (in_ready),
    .sel_o      (sel)
  );

  assign rd_chain[0] = rd_q;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    enc8b10b_lane u_lane (
      .data_i (in_data[g*BYTE_W +: BYTE_W]),
      .k_i    (in_k[g]),
      .rd_i   (rd_chain[g]),
      .sel_i  (sel[g]),
      .code_o (lane_code[g]),
      .rd_o   (rd_chain[g+1]),
      .bad_o  (lane_bad[g])
    );
  end

  assign rd_next = wide_i ? rd_chain[NLANE] : rd_chain[1];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      code_q <= {NLANE{COMMA_NEG}};
      bad_q  <= '0;
      rd_q   <= 1'b0;
    end else begin
      for (int g = 0; g < NLANE; g++) begin
        code_q[g] <= (g == 0 || wide_i) ? lane_code[g] : '0;
        bad_q[g]  <= (g == 0 || wide_i) ? lane_bad[g] : 1'b0;
      end
      rd_q <= rd_next;
    end
  end

  assign code_o = code_q;
  assign bad_o  = bad_q;
  assign rd_o   = rd_q;

  // R5: an unbalanced group on lane 0 always moves the disparity (narrow mode)
  a_r5_flip_on_unbalanced: assert property (@(posedge clk) disable iff (rst)
    (!wide_i && !$past(rst) && $countones(code_o[SYM_W-1:0]) != 5) |-> (rd_o != $past(rd_o)));
  // R5: a group heavy in ones only follows negative disparity
  a_r5_heavy_from_negative: assert property (@(posedge clk) disable iff (rst)
    (!wide_i && $countones(code_o[SYM_W-1:0]) == 6) |-> !$past(rd_o));
  // R8: an invalid-control flag needs an accepted flagged character
  a_r8_bad_needs_flag: assert property (@(posedge clk) disable iff (rst)
    bad_o[0] |-> $past(in_valid && in_ready && in_k[0]));
  // R12: upper lanes are quiet in narrow mode
  a_r12_upper_quiet: assert property (@(posedge clk) disable iff (rst)
    (!wide_i && !$past(rst)) |-> (code_o[NLANE*SYM_W-1:SYM_W] == '0 && bad_o[NLANE-1:1] == '0));
endmodule

// File: tb/enc8b10b_sync_test.sv
module enc8b10b_sync_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic [1:0]  in_k = '0;
  logic [19:0] code_o;
  logic        rd_o;
  logic [1:0]  bad_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  enc8b10b_sync uut (
    .clk      (clk),
    .rst      (rst),
    .wide_i   (wide),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .in_k     (in_k),
    .code_o   (code_o),
    .rd_o     (rd_o),
    .bad_o    (bad_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic look(input string req, input logic [9:0] e_lo, input logic [9:0] e_hi,
                      input logic e_rd, input logic e_rdy, input logic [1:0] e_bad);
    chk(req, "lane0", {22'd0, code_o[9:0]}, {22'd0, e_lo});
    chk(req, "lane1", {22'd0, code_o[19:10]}, {22'd0, e_hi});
    chk(req, "disparity", {31'd0, rd_o}, {31'd0, e_rd});
    chk(req, "ready", {31'd0, in_ready}, {31'd0, e_rdy});
    chk(req, "bad", {30'd0, bad_o}, {30'd0, e_bad});
  endtask

  // drive one word at a negedge, read its code group at the next negedge
  task automatic put(input string req, input logic v, input logic [15:0] d, input logic [1:0] k,
                     input logic [9:0] e_lo, input logic [9:0] e_hi, input logic e_rd, input logic [1:0] e_bad);
    in_valid = v;
    in_data  = d;
    in_k     = k;
    @(negedge clk);
    look(req, e_lo, e_hi, e_rd, 1'b1, e_bad);
  endtask

  task automatic hold_reset(input logic w, input int cycles);
    rst = 1'b1;
    wide = w;
    in_valid = 1'b1;
    in_k = 2'b11;
    for (int i = 0; i < cycles; i++) begin
      in_data = 16'h5A3C + 16'(i * 16'h1111);
      @(negedge clk);
      look("R1", 10'h17C, 10'h17C, 1'b0, 1'b0, 2'b00);
    end
    // junk stays offered through the preamble; it must not be consumed (R10)
    in_data = 16'hFFFF;
    rst = 1'b0;
  endtask

  task automatic t_narrow_preamble;
    hold_reset(1'b0, 4);
    @(negedge clk); look("R2", 10'h17C, 10'h000, 1'b1, 1'b0, 2'b00);
    @(negedge clk); look("R2", 10'h283, 10'h000, 1'b0, 1'b0, 2'b00);
    @(negedge clk); look("R2", 10'h17C, 10'h000, 1'b1, 1'b1, 2'b00);
    put("R2 R4 R10", 1'b1, 16'h00B5, 2'b00, 10'h155, 10'h000, 1'b1, 2'b00);
  endtask

  task automatic t_narrow_stream;
    put("R4", 1'b1, 16'h0000, 2'b00, 10'h346, 10'h000, 1'b1, 2'b00);
    put("R7", 1'b1, 16'h00BC, 2'b01, 10'h283, 10'h000, 1'b0, 2'b00);
    put("R6", 1'b1, 16'h00F1, 2'b00, 10'h3B1, 10'h000, 1'b1, 2'b00);
    put("R6", 1'b1, 16'h00EB, 2'b00, 10'h04B, 10'h000, 1'b0, 2'b00);
    put("R4 R5", 1'b1, 16'h0007, 2'b00, 10'h347, 10'h000, 1'b1, 2'b00);
    put("R7", 1'b1, 16'h00F7, 2'b01, 10'h3A8, 10'h000, 1'b1, 2'b00);
    put("R8", 1'b1, 16'h0038, 2'b01, 10'h24C, 10'h000, 1'b0, 2'b01);
    put("R7", 1'b1, 16'h003C, 2'b01, 10'h27C, 10'h000, 1'b1, 2'b00);
    put("R11", 1'b0, 16'h00B5, 2'b00, 10'h283, 10'h000, 1'b0, 2'b00);
    put("R11", 1'b0, 16'h0000, 2'b01, 10'h17C, 10'h000, 1'b1, 2'b00);
    put("R12", 1'b1, 16'hBC38, 2'b11, 10'h24C, 10'h000, 1'b0, 2'b01);
  endtask

  task automatic t_wide;
    hold_reset(1'b1, 3);
    @(negedge clk); look("R3", 10'h17C, 10'h17C, 1'b1, 1'b0, 2'b00);
    @(negedge clk); look("R3", 10'h283, 10'h17C, 1'b1, 1'b1, 2'b00);
    put("R9 R7", 1'b1, 16'hBCBC, 2'b11, 10'h283, 10'h17C, 1'b1, 2'b00);
    put("R9 R6", 1'b1, 16'hEBF1, 2'b00, 10'h231, 10'h1CB, 1'b1, 2'b00);
    put("R9 R8", 1'b1, 16'hB538, 2'b01, 10'h24C, 10'h155, 1'b0, 2'b01);
    put("R11", 1'b0, 16'h0000, 2'b00, 10'h17C, 10'h283, 1'b0, 2'b00);
  endtask

  task automatic t_reset_midstream;
    in_valid = 1'b1;
    in_data = 16'h00F1;
    in_k = 2'b00;
    @(negedge clk);
    rst = 1'b1;
    in_data = 16'h3838;
    in_k = 2'b11;
    @(negedge clk);
    look("R1", 10'h17C, 10'h17C, 1'b0, 1'b0, 2'b00);
    @(negedge clk);
    look("R1", 10'h17C, 10'h17C, 1'b0, 1'b0, 2'b00);
    hold_reset(1'b0, 2);
    @(negedge clk); look("R2", 10'h17C, 10'h000, 1'b1, 1'b0, 2'b00);
    @(negedge clk); look("R2", 10'h283, 10'h000, 1'b0, 1'b0, 2'b00);
    @(negedge clk); look("R2", 10'h17C, 10'h000, 1'b1, 1'b1, 2'b00);
    put("R2 R10", 1'b1, 16'h00BC, 2'b01, 10'h283, 10'h000, 1'b0, 2'b00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no end, expected end of run");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_narrow_preamble();
    t_narrow_stream();
    t_wide();
    t_reset_midstream();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule